// File: doc/BRIEF.md
# Carrier-Sense Transmit Controller

This block is the per-node transmit gate for a shared broadcast medium. A node raises a packet-pending request. The block then listens to a carrier-detect input during a fixed listening window of time units before it enables its transmitter. One time unit is one clock cycle with the tick enable high. If the window is interrupted by carrier, the block waits for the medium to go quiet and then listens for a full new window. Once it transmits, it holds transmit-enable for a fixed number of units and does not react to carrier, because it has no collision detection.

A one-cycle done pulse marks the end of each transmission. When a request is still pending at that point, the block goes straight back to listening and does not pass through idle. Status outputs show when the block is occupied and when it is waiting on a busy medium. Carrier-detect is assumed to exclude the node's own signal.

Top module: `csma_node_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, tx_en_o, defer_o, busy_o and done_o are all 0 (idle).
- R2: State and counters change only on clock edges where tick_i is 1. An idle block with no pending request, or with no tick, stays idle with busy_o = 0.
- R3: From idle, a tick with pkt_pending_i = 1 and carrier_i = 0 is the first listening unit. After SENSE_LEN consecutive clear ticks, tx_en_o is 1 in the cycle that follows the last of them, and not before.
- R4: A tick with carrier_i = 1 while listening moves the block to waiting. defer_o is 1 from the next cycle, tx_en_o stays 0, and the listening count is discarded.
- R5: While waiting, the first tick with carrier_i = 0 ends the wait and counts as listening unit 1, so SENSE_LEN-1 further clear ticks are needed before tx_en_o rises.
- R6: tx_en_o stays 1 for exactly TX_LEN ticks, whatever carrier_i does during that time.
- R7: done_o is 1 for exactly one cycle, in the cycle where tx_en_o first reads 0 after a transmission.
- R8: If pkt_pending_i is 1 on the final transmit tick, the block listens again with a count of zero: busy_o stays 1, and SENSE_LEN fresh clear ticks are needed, the final transmit tick not counting. Otherwise it returns to idle.
- R9: busy_o is 1 exactly when the block is not idle. defer_o is 1 only while waiting. defer_o and tx_en_o are never both 1.
- R10: A pending request accepted on a tick with carrier_i = 1 goes directly to waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One time unit elapses on this edge |
| pkt_pending_i | input | 1 | A packet is waiting to be sent |
| carrier_i | input | 1 | Another node's signal is present on the medium |
| tx_en_o | output | 1 | Transmitter enable |
| busy_o | output | 1 | Block is not idle |
| defer_o | output | 1 | Waiting for the medium to clear |
| done_o | output | 1 | One-cycle pulse at the end of a transmission |

## Verification
Two events can fall on the same tick: the end of a transmission and the start of the next listening window for a request that is still pending. The bench holds pkt_pending_i high through a transmission and drives carrier_i high on the final transmit tick. It then expects done_o, busy_o = 1 and defer_o = 0 together in the following cycle. It also checks that five more clear ticks are needed before tx_en_o rises again. The other case is the tick on which a wait ends, which also counts as listening unit 1. A behavioural model compares all four outputs on every clock during directed and random traffic.

// File: rtl/csma_pkg.sv
`timescale 1ns/1ps
package csma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SENSE = 2'd1,
    ST_DEFER = 2'd2,
    ST_TX    = 2'd3
  } csma_state_e;
endpackage

// File: rtl/csma_tick_counter.sv
`timescale 1ns/1ps
module csma_tick_counter #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/csma_fsm.sv
`timescale 1ns/1ps
module csma_fsm
  import csma_pkg::*;
#(
  parameter int SENSE_LEN = 5,
  parameter int TX_LEN    = 20,
  parameter int SW        = 3,
  parameter int TW        = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          pend_i,
  input  logic          carrier_i,
  input  logic [SW-1:0] sense_cnt_i,
  input  logic [TW-1:0] tx_cnt_i,
  output csma_state_e   state_o,
  output logic          sense_ld_o,
  output logic [SW-1:0] sense_val_o,
  output logic          sense_inc_o,
  output logic          tx_ld_o,
  output logic          tx_inc_o,
  output logic          done_o
);
  localparam logic [SW-1:0] S_LAST   = SW'(SENSE_LEN - 1);
  localparam logic [TW-1:0] T_LAST   = TW'(TX_LEN - 1);
  localparam bit            ONE_UNIT = (SENSE_LEN == 1);

  csma_state_e state_q, state_d;
  logic        done_q, fin;
  logic        clear_start;

  always_comb begin
    state_d     = state_q;
    sense_ld_o  = 1'b0;
    sense_val_o = '0;
    sense_inc_o = 1'b0;
    tx_ld_o     = 1'b0;
    tx_inc_o    = 1'b0;
    fin         = 1'b0;
    clear_start = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (tick_i && pend_i) begin
          if (carrier_i) state_d = ST_DEFER;
          else           clear_start = 1'b1;
        end
      end
      ST_DEFER: begin
        // first quiet tick both ends the wait and counts as unit 1
        if (tick_i && !carrier_i) clear_start = 1'b1;
      end
      ST_SENSE: begin
        if (tick_i) begin
          if (carrier_i) begin
            state_d    = ST_DEFER;
            sense_ld_o = 1'b1;
          end else if (sense_cnt_i == S_LAST) begin
            state_d = ST_TX;
            tx_ld_o = 1'b1;
          end else begin
            sense_inc_o = 1'b1;
          end
        end
      end
      ST_TX: begin
        // carrier deliberately ignored: no collision detection
        if (tick_i) begin
          if (tx_cnt_i == T_LAST) begin
            fin        = 1'b1;
            sense_ld_o = 1'b1;
            state_d    = pend_i ? ST_SENSE : ST_IDLE;
          end else begin
            tx_inc_o = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (clear_start) begin
      if (ONE_UNIT) begin
        state_d = ST_TX;
        tx_ld_o = 1'b1;
      end else begin
        state_d     = ST_SENSE;
        sense_ld_o  = 1'b1;
        sense_val_o = SW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/csma_node_ctrl.sv
`timescale 1ns/1ps
module csma_node_ctrl
  import csma_pkg::*;
#(
  parameter int SENSE_LEN = 5,
  parameter int TX_LEN    = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pkt_pending_i,
  input  logic carrier_i,
  output logic tx_en_o,
  output logic busy_o,
  output logic defer_o,
  output logic done_o
);
  localparam int SW = $clog2(SENSE_LEN + 1);
  localparam int TW = $clog2(TX_LEN + 1);

  csma_state_e   state;
  logic          sense_ld, sense_inc, tx_ld, tx_inc;
  logic [SW-1:0] sense_val, sense_cnt;
  logic [TW-1:0] tx_cnt;

  csma_fsm #(
    .SENSE_LEN(SENSE_LEN), .TX_LEN(TX_LEN), .SW(SW), .TW(TW)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .pend_i      (pkt_pending_i),
    .carrier_i   (carrier_i),
    .sense_cnt_i (sense_cnt),
    .tx_cnt_i    (tx_cnt),
    .state_o     (state),
    .sense_ld_o  (sense_ld),
    .sense_val_o (sense_val),
    .sense_inc_o (sense_inc),
    .tx_ld_o     (tx_ld),
    .tx_inc_o    (tx_inc),
    .done_o      (done_o)
  );

  csma_tick_counter #(.W(SW)) u_sense_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (sense_ld),
    .ld_val_i (sense_val),
    .inc_i    (sense_inc),
    .cnt_o    (sense_cnt)
  );

  csma_tick_counter #(.W(TW)) u_tx_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (tx_ld),
    .ld_val_i ('0),
    .inc_i    (tx_inc),
    .cnt_o    (tx_cnt)
  );

  assign tx_en_o = (state == ST_TX);
  assign defer_o = (state == ST_DEFER);
  assign busy_o  = (state != ST_IDLE);
endmodule

// File: rtl/csma_node_ctrl_chk.sv
`timescale 1ns/1ps
module csma_node_ctrl_chk #(
  parameter int SENSE_LEN = 5,
  parameter int TX_LEN    = 20
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic tx_en_o,
  input logic busy_o,
  input logic defer_o,
  input logic done_o
);
  int unsigned tx_ticks;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tx_ticks <= 0;
    else if (!tx_en_o)          tx_ticks <= 0;
    else if (tick_i)            tx_ticks <= tx_ticks + 1;
  end

  a_r2_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable({tx_en_o, busy_o, defer_o}));

  a_r3_tx_after_sense: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SENSE_LEN > 1) && $rose(tx_en_o) |-> $past(busy_o && !defer_o));

  a_r6_tx_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_en_o) |-> (tx_ticks == TX_LEN));

  a_r7_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tx_en_o && $past(tx_en_o));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_status_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o || defer_o) |-> busy_o && !(tx_en_o && defer_o));
endmodule

bind csma_node_ctrl csma_node_ctrl_chk #(
  .SENSE_LEN(SENSE_LEN), .TX_LEN(TX_LEN)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .tx_en_o (tx_en_o),
  .busy_o  (busy_o),
  .defer_o (defer_o),
  .done_o  (done_o)
);

// File: tb/csma_node_ctrl_bench.sv
`timescale 1ns/1ps
module csma_node_ctrl_bench;
  localparam int SL = 5;
  localparam int TL = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, pend = 1'b0, carr = 1'b0;
  logic tx_en, busy, defer, done;
  int   n_tests = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  csma_node_ctrl #(.SENSE_LEN(SL), .TX_LEN(TL)) u_csma_node_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pkt_pending_i(pend),
    .carrier_i(carr), .tx_en_o(tx_en), .busy_o(busy), .defer_o(defer),
    .done_o(done)
  );

  // behavioural reference: mode 0 idle, 1 listen, 2 wait, 3 send
  int m_mode, m_heard, m_left;
  bit m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_heard = 0; m_left = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (tick) begin
        if ((m_mode == 0 && pend && carr)) m_mode = 2;
        else if ((m_mode == 0 && pend) || (m_mode == 2 && !carr)) begin
          m_heard = 1;
          if (m_heard >= SL) begin m_mode = 3; m_left = TL; end
          else m_mode = 1;
        end else if (m_mode == 1) begin
          if (carr) m_mode = 2;
          else begin
            m_heard++;
            if (m_heard >= SL) begin m_mode = 3; m_left = TL; end
          end
        end else if (m_mode == 3) begin
          m_left--;
          if (m_left == 0) begin
            m_done = 1; m_heard = 0;
            m_mode = pend ? 1 : 0;
          end
        end
      end
    end
  end

  task automatic cmp(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s got %0b exp %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cmp("R6 tx_en_o lockstep", tx_en, m_mode == 3);
      cmp("R4 defer_o lockstep", defer, m_mode == 2);
      cmp("R9 busy_o lockstep",  busy,  m_mode != 0);
      cmp("R7 done_o lockstep",  done,  m_done);
    end
  end

  task automatic step(input logic t, input logic p, input logic c);
    tick = t; pend = p; carr = c;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cmp("R1 reset tx_en", tx_en, 1'b0);
    cmp("R1 reset busy",  busy,  1'b0);
    cmp("R1 reset done",  done,  1'b0);
    rst_n = 1'b1;
    step(0, 0, 0);
    cmp("R1 after release busy", busy, 1'b0);

    // R2: no tick, or tick without request
    for (int i = 0; i < 3; i++) step(0, 1, 0);
    cmp("R2 no tick stays idle", busy, 1'b0);
    for (int i = 0; i < 3; i++) step(1, 0, 1);
    cmp("R2 no request stays idle", busy, 1'b0);

    // R3: five clear ticks then transmit
    for (int k = 1; k <= SL; k++) begin
      step(1, (k == 1), 0);
      cmp("R3 tx timing", tx_en, (k == SL));
    end
    // R6: carrier toggles during transmission
    for (int k = 1; k <= TL; k++) begin
      step(1, 0, k[0]);
      cmp("R6 tx held", tx_en, (k < TL));
      if (k == TL) cmp("R7 done at end", done, 1'b1);
    end
    step(0, 0, 0);
    cmp("R7 done single cycle", done, 1'b0);
    cmp("R8 idle without request", busy, 1'b0);

    // R10 then R5
    step(1, 1, 1);
    cmp("R10 accept into wait", defer, 1'b1);
    for (int i = 0; i < 3; i++) step(1, 0, 1);
    cmp("R4 still waiting", defer, 1'b1);
    step(1, 0, 0);
    cmp("R5 wait ends", defer, 1'b0);
    cmp("R5 still busy", busy, 1'b1);
    for (int k = 2; k <= SL; k++) begin
      step(1, 0, 0);
      cmp("R5 quiet tick counts as unit one", tx_en, (k == SL));
    end
    // R8: request held, carrier on the final transmit tick
    for (int k = 1; k <= TL; k++) step(1, 1, (k == TL));
    cmp("R8 done with re-request", done, 1'b1);
    cmp("R8 busy kept",  busy,  1'b1);
    cmp("R8 not waiting", defer, 1'b0);
    for (int k = 1; k <= SL; k++) begin
      step(1, 0, 0);
      cmp("R8 fresh window", tx_en, (k == SL));
    end
    for (int k = 1; k <= TL; k++) step(1, 0, 0);
    cmp("R8 back idle", busy, 1'b0);

    // R4: carrier mid window, gaps without tick
    step(1, 1, 0);
    step(0, 0, 1);
    step(1, 0, 0);
    step(1, 0, 1);
    cmp("R4 carrier in window", defer, 1'b1);
    cmp("R4 no tx", tx_en, 1'b0);
    step(1, 0, 0);
    for (int k = 2; k <= SL; k++) step(1, 0, 0);
    cmp("R3 tx after restart", tx_en, 1'b1);
    for (int k = 1; k <= TL; k++) step(1, 0, 0);

    // random traffic checked by the lockstep model
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 4) == 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL R2 watchdog got running exp finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule